// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block owns a small store queue and decides, for every load, where that load's data comes from. The core writes each store into a queue slot that it picks. A store carries an address, a size code, up to 16 bytes of data and an age tag, and it stays in its slot until the core commits it. When a load arrives with an address, size, vector flag and age, the block compares it against every live store that is older than the load. It returns one of three verdicts: forward the bytes from a store, wait for a store to commit, or read the cache.

Two checks run for each load. The full-address check picks the youngest older store that overlaps the load. It then tests whether that store contains the load. A vector load must also meet an alignment rule to forward. The early check compares only the page offset, which is the low 12 address bits. A hit in the early check delays the result by one cycle, even when the full addresses differ. A load that sees such a hit holds off the next load for one cycle, so results never collide at the output.

Top module: `sfw_forward_check`

## Requirements
- R1: After reset the queue holds no live store, `res_valid_o` is 0 and `ld_ready_o` is 1.
- R2: A store written to a slot stays live until a commit names that slot. After the commit, the store has no effect on later loads. When a write and a commit name the same slot in the same cycle, the write wins. The size code gives 1 << code bytes for codes 0 to 3 and 16 bytes for codes 4 and above.
- R3: An integer load (`ld_vec_i`=0) gets verdict FWD (1) when all of its bytes lie inside the selected store, at any byte offset. Byte b of `res_data_o` then equals store byte (offset + b), and the bytes at and above the load size are 0.
- R4: A vector load forwards only when its offset from the selected store's address is 0 or half the store size. A contained vector load at any other offset gets verdict WAIT (2).
- R5: A store is older than a load when (load age − store age) mod 2^AGE_W is nonzero and has its top bit clear. Among the live older stores that overlap the load, only the youngest is selected, using the same rule between two stores. Stores that are not older than the load are ignored. Live stores hold distinct ages.
- R6: When the selected store does not contain the load, the verdict is WAIT and `res_data_o` is 0.
- R7: When no live older store overlaps the load, the verdict is CACHE (0) and `res_data_o` is 0.
- R8: Without a page-offset hit, the result is valid in the second cycle after the cycle in which the load is accepted. No result is ever valid in the first cycle after acceptance. An exact-address forward takes the same latency as a forward at a nonzero offset.
- R9: A page-offset hit means some live older store overlaps the load when both are reduced to byte ranges [offset, offset + size) over address bits [11:0], with no wraparound. Such a hit delays the result to the third cycle after acceptance, even when the verdict is CACHE.
- R10: In the first cycle after a load with a page-offset hit is accepted, `ld_ready_o` is 0. In every other cycle it is 1, and a load is accepted only in a cycle where both `ld_valid_i` and `ld_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid_i | input | 1 | Write a store into a slot |
| st_slot_i | input | 3 | Target slot |
| st_addr_i | input | 40 | Store byte address |
| st_size_i | input | 3 | Store size code |
| st_data_i | input | 128 | Store data, byte 0 at the store address |
| st_age_i | input | 8 | Store age tag |
| cm_valid_i | input | 1 | Commit and free a slot |
| cm_slot_i | input | 3 | Slot to free |
| ld_valid_i | input | 1 | Load request |
| ld_ready_o | output | 1 | Load can be accepted this cycle |
| ld_addr_i | input | 40 | Load byte address |
| ld_size_i | input | 3 | Load size code |
| ld_vec_i | input | 1 | Load targets vector registers |
| ld_age_i | input | 8 | Load age tag |
| res_valid_o | output | 1 | Result valid |
| res_verdict_o | output | 2 | 0 CACHE, 1 FWD, 2 WAIT |
| res_data_o | output | 128 | Forwarded bytes, load byte 0 at bit 0 |

## Verification
A load is accepted at a rising edge. The result appears two cycles later, or three cycles later after a page-offset hit. The bench works out which of the two latencies applies from its own byte-level model before it drives the load. It then counts falling edges after the accepting edge. At every edge before the due cycle it requires `res_valid_o` to be low, and in the due cycle it checks the verdict and the bytes. It also samples `ld_ready_o` in the first cycle after acceptance, so the one-cycle hold-off is checked against the same latency model.

// File: rtl/sfw_pkg.sv
`timescale 1ns/1ps
package sfw_pkg;
    localparam int LINE_BYTES = 16;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    typedef enum logic [1:0] {
        VERD_CACHE = 2'd0,
        VERD_FWD   = 2'd1,
        VERD_WAIT  = 2'd2
    } verdict_e;

    // size code -> byte count: 1,2,4,8 then 16 for every larger code
    function automatic logic [4:0] size_bytes(input logic [2:0] code);
        size_bytes = (code >= 3'd4) ? 5'd16 : (5'd1 << code);
    endfunction
endpackage

// File: rtl/sfw_queue.sv
`timescale 1ns/1ps
module sfw_queue
    import sfw_pkg::*;
#(
    parameter int AW    = 40,
    parameter int DEPTH = 8,
    parameter int AGE_W = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic [AW-1:0]        wr_addr,
    input  logic [2:0]           wr_code,
    input  logic [LINE_BITS-1:0] wr_data,
    input  logic [AGE_W-1:0]     wr_age,
    input  logic                 cm_en,
    input  logic [SLOT_W-1:0]    cm_slot,
    output logic [DEPTH-1:0]     ent_vld,
    output logic [AW-1:0]        ent_addr [DEPTH],
    output logic [2:0]           ent_code [DEPTH],
    output logic [LINE_BITS-1:0] ent_data [DEPTH],
    output logic [AGE_W-1:0]     ent_age  [DEPTH]
);
    typedef struct packed {
        logic [AW-1:0]        addr;
        logic [2:0]           code;
        logic [LINE_BITS-1:0] data;
        logic [AGE_W-1:0]     age;
    } entry_t;

    logic [DEPTH-1:0] vld_d, vld_q;
    entry_t           ent_d [DEPTH];
    entry_t           ent_q [DEPTH];

    always_comb begin
        vld_d = vld_q;
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        if (cm_en) vld_d[cm_slot] = 1'b0;
        if (wr_en) begin
            vld_d[wr_slot]      = 1'b1;
            ent_d[wr_slot].addr = wr_addr;
            ent_d[wr_slot].code = wr_code;
            ent_d[wr_slot].data = wr_data;
            ent_d[wr_slot].age  = wr_age;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        ent_vld = vld_q;
        for (int i = 0; i < DEPTH; i++) begin
            ent_addr[i] = ent_q[i].addr;
            ent_code[i] = ent_q[i].code;
            ent_data[i] = ent_q[i].data;
            ent_age[i]  = ent_q[i].age;
        end
    end

    AST_COMMIT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        cm_en && !(wr_en && wr_slot == cm_slot) |=> !vld_q[$past(cm_slot)]); // R2
    AST_WRITE_LIVES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(wr_slot)]); // R2
endmodule

// File: rtl/sfw_match.sv
`timescale 1ns/1ps
module sfw_match
    import sfw_pkg::*;
#(
    parameter int AW        = 40,
    parameter int AGE_W     = 8,
    parameter int PAGE_BITS = 12
) (
    input  logic             st_vld,
    input  logic [AW-1:0]    st_addr,
    input  logic [2:0]       st_code,
    input  logic [AGE_W-1:0] st_age,
    input  logic [AW-1:0]    ld_addr,
    input  logic [2:0]       ld_code,
    input  logic             ld_vec,
    input  logic [AGE_W-1:0] ld_age,
    output logic             cand,
    output logic             fwd_ok,
    output logic             page_hit,
    output logic [3:0]       offset
);
    logic [4:0]           st_b, ld_b;
    logic [AW:0]          st_end, ld_end;
    logic [PAGE_BITS:0]   st_lo, ld_lo, st_lo_end, ld_lo_end;
    logic [AGE_W-1:0]     age_gap;
    logic                 older, overlap, contain, align_ok;

    always_comb begin
        st_b      = size_bytes(st_code);
        ld_b      = size_bytes(ld_code);
        age_gap   = ld_age - st_age;
        older     = (age_gap != '0) && !age_gap[AGE_W-1];
        st_end    = {1'b0, st_addr} + (AW+1)'(st_b);
        ld_end    = {1'b0, ld_addr} + (AW+1)'(ld_b);
        overlap   = ({1'b0, ld_addr} < st_end) && ({1'b0, st_addr} < ld_end);
        contain   = (ld_addr >= st_addr) && (ld_end <= st_end);
        offset    = ld_addr[3:0] - st_addr[3:0];
        align_ok  = (offset == 4'd0) || ({1'b0, offset} == (st_b >> 1));
        cand      = st_vld && older && overlap;
        fwd_ok    = contain && (!ld_vec || align_ok);
        st_lo     = {1'b0, st_addr[PAGE_BITS-1:0]};
        ld_lo     = {1'b0, ld_addr[PAGE_BITS-1:0]};
        st_lo_end = st_lo + (PAGE_BITS+1)'(st_b);
        ld_lo_end = ld_lo + (PAGE_BITS+1)'(ld_b);
        page_hit  = st_vld && older && (ld_lo < st_lo_end) && (st_lo < ld_lo_end);
    end
endmodule

// File: rtl/sfw_select.sv
`timescale 1ns/1ps
module sfw_select #(
    parameter int DEPTH = 8,
    parameter int AGE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] cand,
    input  logic [AGE_W-1:0] age [DEPTH],
    output logic [DEPTH-1:0] pick
);
    // entry i wins when no other candidate is younger than it
    for (genvar i = 0; i < DEPTH; i++) begin : g_pick
        logic [DEPTH-1:0] beaten;
        for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
            if (i == j) begin : g_self
                assign beaten[j] = 1'b0;
            end else begin : g_other
                logic [AGE_W-1:0] gap;
                assign gap       = age[j] - age[i];
                assign beaten[j] = cand[j] && (gap != '0) && !gap[AGE_W-1];
            end
        end
        assign pick[i] = cand[i] && (beaten == '0);
    end

    AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick)); // R5
    AST_PICK_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cand != '0) |-> (pick != '0)); // R5
endmodule

// File: rtl/sfw_forward_check.sv
`timescale 1ns/1ps
module sfw_forward_check
    import sfw_pkg::*;
#(
    parameter int AW        = 40,
    parameter int DEPTH     = 8,
    parameter int AGE_W     = 8,
    parameter int PAGE_BITS = 12,
    localparam int SLOT_W   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid_i,
    input  logic [SLOT_W-1:0]    st_slot_i,
    input  logic [AW-1:0]        st_addr_i,
    input  logic [2:0]           st_size_i,
    input  logic [LINE_BITS-1:0] st_data_i,
    input  logic [AGE_W-1:0]     st_age_i,
    input  logic                 cm_valid_i,
    input  logic [SLOT_W-1:0]    cm_slot_i,
    input  logic                 ld_valid_i,
    output logic                 ld_ready_o,
    input  logic [AW-1:0]        ld_addr_i,
    input  logic [2:0]           ld_size_i,
    input  logic                 ld_vec_i,
    input  logic [AGE_W-1:0]     ld_age_i,
    output logic                 res_valid_o,
    output logic [1:0]           res_verdict_o,
    output logic [LINE_BITS-1:0] res_data_o
);
    typedef struct packed {
        logic             vld;
        logic [AW-1:0]    addr;
        logic [2:0]       code;
        logic             vec;
        logic [AGE_W-1:0] age;
    } req_t;

    typedef struct packed {
        logic                 vld;
        verdict_e             verd;
        logic [LINE_BITS-1:0] data;
    } res_t;

    typedef struct packed {
        req_t s1;
        res_t s2;
        logic s2_pen;
        res_t s3;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH-1:0]     q_vld;
    logic [AW-1:0]        q_addr [DEPTH];
    logic [2:0]           q_code [DEPTH];
    logic [LINE_BITS-1:0] q_data [DEPTH];
    logic [AGE_W-1:0]     q_age  [DEPTH];

    sfw_queue #(.AW(AW), .DEPTH(DEPTH), .AGE_W(AGE_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .wr_en(st_valid_i), .wr_slot(st_slot_i), .wr_addr(st_addr_i),
        .wr_code(st_size_i), .wr_data(st_data_i), .wr_age(st_age_i),
        .cm_en(cm_valid_i), .cm_slot(cm_slot_i),
        .ent_vld(q_vld), .ent_addr(q_addr), .ent_code(q_code),
        .ent_data(q_data), .ent_age(q_age)
    );

    logic [DEPTH-1:0] cand, fwd_ok, page_hit, pick;
    logic [3:0]       offset [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        sfw_match #(.AW(AW), .AGE_W(AGE_W), .PAGE_BITS(PAGE_BITS)) u_match (
            .st_vld(q_vld[i]), .st_addr(q_addr[i]), .st_code(q_code[i]),
            .st_age(q_age[i]),
            .ld_addr(st_q.s1.addr), .ld_code(st_q.s1.code),
            .ld_vec(st_q.s1.vec), .ld_age(st_q.s1.age),
            .cand(cand[i]), .fwd_ok(fwd_ok[i]), .page_hit(page_hit[i]),
            .offset(offset[i])
        );
    end

    sfw_select #(.DEPTH(DEPTH), .AGE_W(AGE_W)) u_select (
        .clk(clk), .rst_n(rst_n), .cand(cand), .age(q_age), .pick(pick)
    );

    logic                 alias_hit, sel_ok;
    logic [3:0]           sel_off;
    logic [LINE_BITS-1:0] sel_data, ld_mask, fwd_bytes;
    logic [4:0]           ld_b;

    always_comb begin
        sel_ok   = 1'b0;
        sel_off  = '0;
        sel_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick[i]) begin
                sel_ok   = sel_ok | fwd_ok[i];
                sel_off  = sel_off | offset[i];
                sel_data = sel_data | q_data[i];
            end
        end
        alias_hit = st_q.s1.vld && (page_hit != '0);
        ld_b      = size_bytes(st_q.s1.code);
        ld_mask   = (ld_b == 5'd16) ? '1
                  : ((LINE_BITS'(1) << {ld_b, 3'b000}) - LINE_BITS'(1));
        fwd_bytes = (sel_data >> {sel_off, 3'b000}) & ld_mask;
        ld_ready_o = !alias_hit;
    end

    always_comb begin
        st_d = st_q;
        st_d.s1.vld  = ld_valid_i && ld_ready_o;
        st_d.s1.addr = ld_addr_i;
        st_d.s1.code = ld_size_i;
        st_d.s1.vec  = ld_vec_i;
        st_d.s1.age  = ld_age_i;

        st_d.s2.vld  = st_q.s1.vld;
        st_d.s2_pen  = alias_hit;
        if (pick == '0) begin
            st_d.s2.verd = VERD_CACHE;
            st_d.s2.data = '0;
        end else if (sel_ok) begin
            st_d.s2.verd = VERD_FWD;
            st_d.s2.data = fwd_bytes;
        end else begin
            st_d.s2.verd = VERD_WAIT;
            st_d.s2.data = '0;
        end

        st_d.s3     = st_q.s2;
        st_d.s3.vld = st_q.s2.vld && st_q.s2_pen;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.s3.vld) begin
            res_valid_o   = 1'b1;
            res_verdict_o = st_q.s3.verd;
            res_data_o    = st_q.s3.data;
        end else if (st_q.s2.vld && !st_q.s2_pen) begin
            res_valid_o   = 1'b1;
            res_verdict_o = st_q.s2.verd;
            res_data_o    = st_q.s2.data;
        end else begin
            res_valid_o   = 1'b0;
            res_verdict_o = VERD_CACHE;
            res_data_o    = '0;
        end
    end

    AST_BASE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.vld && !alias_hit |=> res_valid_o); // R8
    AST_ALIAS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |=> !res_valid_o ##1 res_valid_o); // R9
    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.s3.vld && st_q.s2.vld && !st_q.s2_pen)); // R10
    AST_NONFWD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o && res_verdict_o != VERD_FWD |-> res_data_o == '0); // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |=> !st_q.s1.vld); // R10
endmodule

// File: tb/tb_sfw_forward_check.sv
`timescale 1ns/1ps
module tb_sfw_forward_check;
    localparam int AW = 40;
    localparam int DEPTH = 8;
    localparam int AGE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid_i = 0;
    logic [2:0] st_slot_i = 0;
    logic [AW-1:0] st_addr_i = 0;
    logic [2:0] st_size_i = 0;
    logic [127:0] st_data_i = 0;
    logic [AGE_W-1:0] st_age_i = 0;
    logic cm_valid_i = 0;
    logic [2:0] cm_slot_i = 0;
    logic ld_valid_i = 0;
    logic ld_ready_o;
    logic [AW-1:0] ld_addr_i = 0;
    logic [2:0] ld_size_i = 0;
    logic ld_vec_i = 0;
    logic [AGE_W-1:0] ld_age_i = 0;
    logic res_valid_o;
    logic [1:0] res_verdict_o;
    logic [127:0] res_data_o;

    always #2.5 clk = ~clk;

    sfw_forward_check dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid_i(st_valid_i), .st_slot_i(st_slot_i), .st_addr_i(st_addr_i),
        .st_size_i(st_size_i), .st_data_i(st_data_i), .st_age_i(st_age_i),
        .cm_valid_i(cm_valid_i), .cm_slot_i(cm_slot_i),
        .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o), .ld_addr_i(ld_addr_i),
        .ld_size_i(ld_size_i), .ld_vec_i(ld_vec_i), .ld_age_i(ld_age_i),
        .res_valid_o(res_valid_o), .res_verdict_o(res_verdict_o),
        .res_data_o(res_data_o)
    );

    int n_checks = 0;
    int n_fail = 0;

    // reference model of the queue
    bit           m_v    [DEPTH];
    logic [AW-1:0] m_addr [DEPTH];
    logic [2:0]   m_code [DEPTH];
    logic [127:0] m_data [DEPTH];
    logic [7:0]   m_age  [DEPTH];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [2:0] c);
        return (c >= 3'd4) ? 16 : (1 << c);
    endfunction

    function automatic bit gap_pos(input logic [7:0] later, input logic [7:0] earlier);
        logic [7:0] d;
        d = later - earlier;
        return (d != 8'd0) && !d[7];
    endfunction

    function automatic logic [127:0] pattern(input int seed);
        logic [127:0] p;
        for (int b = 0; b < 16; b++) p[b*8 +: 8] = 8'(seed * 16 + b + 1);
        return p;
    endfunction

    task automatic store(input int slot, input logic [AW-1:0] a, input logic [2:0] c,
                         input logic [127:0] d, input logic [7:0] age);
        @(negedge clk);
        st_valid_i = 1; st_slot_i = 3'(slot); st_addr_i = a; st_size_i = c;
        st_data_i = d; st_age_i = age;
        @(negedge clk);
        st_valid_i = 0;
        m_v[slot] = 1; m_addr[slot] = a; m_code[slot] = c;
        m_data[slot] = d; m_age[slot] = age;
    endtask

    task automatic commit(input int slot);
        @(negedge clk);
        cm_valid_i = 1; cm_slot_i = 3'(slot);
        @(negedge clk);
        cm_valid_i = 0;
        m_v[slot] = 0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < DEPTH; s++) commit(s);
    endtask

    task automatic model(input logic [AW-1:0] a, input logic [2:0] c, input bit vec,
                         input logic [7:0] age, output logic [1:0] verd,
                         output logic [127:0] data, output int lat);
        longint la, ls, sa, ss, off, lo_l, lo_s;
        int best;
        bit al;
        best = -1; al = 0; data = '0;
        la = longint'(a); ls = nbytes(c);
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i] && gap_pos(age, m_age[i])) begin
                sa = longint'(m_addr[i]); ss = nbytes(m_code[i]);
                if (la < sa + ss && sa < la + ls)
                    if (best < 0 || gap_pos(m_age[i], m_age[best])) best = i;
                lo_l = la % 4096; lo_s = sa % 4096;
                if (lo_l < lo_s + ss && lo_s < lo_l + ls) al = 1;
            end
        end
        lat = al ? 3 : 2;
        if (best < 0) verd = 2'd0;
        else begin
            sa = longint'(m_addr[best]); ss = nbytes(m_code[best]);
            off = la - sa;
            if (la >= sa && la + ls <= sa + ss && (!vec || off == 0 || off == ss / 2)) begin
                verd = 2'd1;
                for (int b = 0; b < ls; b++)
                    data[b*8 +: 8] = m_data[best][(int'(off) + b)*8 +: 8];
            end else verd = 2'd2;
        end
    endtask

    task automatic do_load(input logic [AW-1:0] a, input logic [2:0] c, input bit vec,
                           input logic [7:0] age, input string req);
        logic [1:0] ev;
        logic [127:0] ed;
        int lat;
        model(a, c, vec, age, ev, ed, lat);
        @(negedge clk);
        ld_valid_i = 1; ld_addr_i = a; ld_size_i = c; ld_vec_i = vec; ld_age_i = age;
        check(ld_ready_o == 1'b1, "R10", "ready before issue", 128'(ld_ready_o), 1);
        @(posedge clk);
        for (int n = 1; n <= lat; n++) begin
            @(negedge clk);
            if (n == 1) begin
                ld_valid_i = 0;
                check(ld_ready_o == (lat == 2), "R10", "ready after accept",
                      128'(ld_ready_o), 128'(lat == 2));
            end
            if (n < lat)
                check(res_valid_o == 1'b0, (lat == 3) ? "R9" : "R8", "early valid",
                      128'(res_valid_o), 0);
            else begin
                check(res_valid_o == 1'b1, (lat == 3) ? "R9" : "R8", "valid at due cycle",
                      128'(res_valid_o), 1);
                check(res_verdict_o == ev, req, "verdict", 128'(res_verdict_o), 128'(ev));
                check(res_data_o == ed, req, "data", res_data_o, ed);
            end
        end
    endtask

    task automatic t_reset();
        check(res_valid_o == 1'b0, "R1", "valid after reset", 128'(res_valid_o), 0);
        check(ld_ready_o == 1'b1, "R1", "ready after reset", 128'(ld_ready_o), 1);
        do_load(40'h100, 3'd3, 0, 8'd5, "R1"); // empty queue: CACHE, 2 cycles
    endtask

    task automatic t_int_forward(); // R3, R8
        store(0, 40'h1000, 3'd4, pattern(1), 8'd10);
        do_load(40'h1000, 3'd3, 0, 8'd11, "R3"); // exact match
        do_load(40'h1005, 3'd1, 0, 8'd11, "R3");
        do_load(40'h100F, 3'd0, 0, 8'd11, "R3");
        do_load(40'h1008, 3'd3, 0, 8'd11, "R8");
        do_load(40'h1003, 3'd2, 0, 8'd11, "R3");
        clear_all();
    endtask

    task automatic t_vec_align(); // R4
        store(1, 40'h2000, 3'd4, pattern(2), 8'd20);
        do_load(40'h2000, 3'd3, 1, 8'd21, "R4");
        do_load(40'h2008, 3'd3, 1, 8'd21, "R4");
        do_load(40'h2004, 3'd2, 1, 8'd21, "R4"); // misaligned: WAIT
        do_load(40'h200C, 3'd2, 1, 8'd21, "R4");
        do_load(40'h2004, 3'd2, 0, 8'd21, "R3"); // integer: forwards
        clear_all();
    endtask

    task automatic t_youngest(); // R5
        store(2, 40'h3000, 3'd3, pattern(3), 8'd30);
        store(3, 40'h3000, 3'd3, pattern(4), 8'd32);
        do_load(40'h3000, 3'd3, 0, 8'd35, "R5");
        do_load(40'h3002, 3'd1, 0, 8'd31, "R5");
        do_load(40'h3000, 3'd3, 0, 8'd29, "R5"); // both younger: CACHE
        clear_all();
        store(4, 40'h3800, 3'd3, pattern(5), 8'd250);
        do_load(40'h3804, 3'd2, 0, 8'd3, "R5"); // age wrap
        clear_all();
    endtask

    task automatic t_partial(); // R6, R2
        store(5, 40'h4000, 3'd2, pattern(6), 8'd40);
        do_load(40'h4002, 3'd2, 0, 8'd41, "R6");
        store(6, 40'h4000, 3'd4, pattern(7), 8'd38);
        do_load(40'h4002, 3'd2, 0, 8'd41, "R6"); // youngest is partial
        commit(5);
        do_load(40'h4002, 3'd2, 0, 8'd41, "R2"); // older full store now used
        commit(6);
        do_load(40'h4002, 3'd2, 0, 8'd41, "R2"); // committed: CACHE
        clear_all();
    endtask

    task automatic t_alias(); // R9, R7
        store(6, 40'h12_3456_7100, 3'd3, pattern(8), 8'd50);
        do_load(40'h00_0000_0104, 3'd2, 0, 8'd51, "R9");
        do_load(40'h00_0000_0200, 3'd2, 0, 8'd51, "R7");
        do_load(40'h00_0000_0108, 3'd3, 0, 8'd51, "R7"); // adjacent, no overlap
        clear_all();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i] = 0; m_addr[i] = '0; m_code[i] = '0; m_data[i] = '0; m_age[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_int_forward();
        t_vec_align();
        t_youngest();
        t_partial();
        t_alias();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule